// File: doc/BRIEF.md
# Character LCD Controller Host Register Interface

This block is the host-facing side of a dot-matrix character LCD controller. A microcontroller reaches it through a strobe (`acc`), a register-select line (`rs`), a direction line (`rw`) and an 8-bit data path. The two select lines choose one of four operations: writing a command, reading status, writing display data and reading display data. The block holds one address counter shared by an 80-byte display RAM and a 64-byte character-pattern RAM, both modelled inside. It also holds a data register that prefetches the addressed RAM byte, so that every data read returns a value fetched ahead of time.

Each accepted command or data transfer starts a fixed busy interval. While it lasts, only status reads are served, and the status byte reports the address counter as it stood before the running operation was accepted. In narrow mode (`nib4` = 1) each byte moves as two 4-bit transfers on bits 7..4, high nibble first. The operation executes when the second nibble arrives. Command decoding beyond address setting is reduced to the busy interval.

The control core is a two-state machine. `ST_READY` accepts every access. A complete non-status byte takes the transition *exec* to `ST_BUSY` and loads a cycle counter. `ST_BUSY` serves status reads only, counts down, and takes the transition *done* back to `ST_READY` when the counter reaches zero.

Top module: `lcd_host_if`

## Requirements
- R1: The pair {rs,rw} selects the operation on an accepted strobe: 00 command write, 01 status read, 10 data write, 11 data read.
- R2: A status read returns busy in bit 7 and an address in bits 6..0. While busy, that address is the counter value from before the running operation was accepted; when idle it is the current counter.
- R3: A command with bit 7 = 1 selects the display RAM and loads bits 6..0 into the counter, reduced by 80 when 80 or above. A command with bits 7..6 = 01 selects the character RAM and loads bits 5..0. A command with bits 7..6 = 00 leaves the counter and the RAM selection unchanged.
- R4: An address-setting command copies the byte at the new address into the data register, so the next data read returns it.
- R5: A data write stores the byte at the addressed location of the selected RAM, leaves that byte in the data register and advances the counter.
- R6: A data read returns the data register, then advances the counter and reloads the data register from the new address.
- R7: The counter wraps from 79 to 0 in the display RAM and from 63 to 0 in the character RAM.
- R8: An executed command holds `busy` high for INSTR_CYC cycles, and an executed data transfer for DATA_CYC cycles. The interval starts in the cycle after the accepting edge.
- R9: While busy, command writes, data writes and data reads are ignored: RAM, counter and `dout` keep their values.
- R10: With `nib4` = 1 each byte is sent on din[7:4] high nibble first and read back on dout[7:4] high nibble first, with dout[3:0] = 0. The operation executes on the second nibble.
- R11: After a complete command write in narrow mode, the next access is taken as a high nibble.
- R12: Reset clears the counter, selects the display RAM, clears busy and the data register, and drives `dout` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc | input | 1 | Access strobe, one transfer per cycle it is high |
| rs | input | 1 | Register select: 0 command/status, 1 data |
| rw | input | 1 | Direction: 0 write, 1 read |
| nib4 | input | 1 | 1 selects the 4-bit transfer mode |
| din | input | 8 | Write data (bits 7..4 only in 4-bit mode) |
| dout | output | 8 | Read data, registered at the accepting edge |
| busy | output | 1 | High while an operation executes |

## Verification
The checks assume the host changes `nib4` only between complete bytes, and that in 4-bit mode both nibbles of a byte carry the same operation. The bench always sends nibbles in pairs of the same kind and changes mode only after a full settle period. The assertions on ignored accesses and on the busy interval treat any strobe during busy as legal. The bench issues such strobes on purpose, and otherwise waits out the busy interval before the next non-status access.

// File: rtl/lcdh_pkg.sv
package lcdh_pkg;

    typedef enum logic [1:0] {
        OP_IRW  = 2'b00,
        OP_STAT = 2'b01,
        OP_DRW  = 2'b10,
        OP_DRR  = 2'b11
    } op_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_BUSY  = 1'b1
    } st_e;

endpackage

// File: rtl/lcdh_nibble.sv
module lcdh_nibble
    import lcdh_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          rs,
    input  logic          rw,
    input  logic          nib4,
    input  logic          allow,
    input  logic [DW-1:0] din,
    output logic          take,
    output logic          byte_vld,
    output op_e           op,
    output logic [DW-1:0] bdata,
    output logic          lo_phase
);
    localparam int HW = DW / 2;

    logic [HW-1:0] hold_q;
    logic          tog_q;

    assign op       = op_e'({rs, rw});
    assign take     = acc && (allow || op == OP_STAT);
    assign byte_vld = take && (!nib4 || tog_q);
    assign bdata    = nib4 ? {hold_q, din[DW-1:HW]} : din;
    assign lo_phase = tog_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q  <= 1'b0;
            hold_q <= '0;
        end else if (!nib4) begin
            tog_q <= 1'b0;
        end else if (take) begin
            if (!tog_q) begin
                hold_q <= din[DW-1:HW];
                tog_q  <= 1'b1;
            end else begin
                tog_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lcdh_addr.sv
module lcdh_addr #(
    parameter int AW       = 7,
    parameter int DD_DEPTH = 80,
    parameter int CG_DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_dd,
    input  logic          ld_cg,
    input  logic [AW-1:0] ld_val,
    input  logic          inc,
    input  logic          freeze,
    output logic [AW-1:0] ac,
    output logic          cg_sel,
    output logic [AW-1:0] snap,
    output logic [AW-1:0] nxt,
    output logic          nxt_cg
);
    localparam int CGW = $clog2(CG_DEPTH);
    localparam logic [AW-1:0] DD_LAST = AW'(DD_DEPTH - 1);
    localparam logic [AW-1:0] CG_LAST = AW'(CG_DEPTH - 1);
    localparam logic [AW-1:0] DD_SPAN = AW'(DD_DEPTH);

    logic [AW-1:0] ac_q, snap_q, inc_val, dd_val, cg_val;
    logic          cg_q;

    always_comb begin
        if (cg_q) inc_val = (ac_q == CG_LAST) ? '0 : ac_q + 1'b1;
        else      inc_val = (ac_q == DD_LAST) ? '0 : ac_q + 1'b1;
        dd_val = (ld_val >= DD_SPAN) ? ld_val - DD_SPAN : ld_val;
        cg_val = AW'(ld_val[CGW-1:0]);
        if (ld_dd) begin
            nxt    = dd_val;
            nxt_cg = 1'b0;
        end else if (ld_cg) begin
            nxt    = cg_val;
            nxt_cg = 1'b1;
        end else if (inc) begin
            nxt    = inc_val;
            nxt_cg = cg_q;
        end else begin
            nxt    = ac_q;
            nxt_cg = cg_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q   <= '0;
            cg_q   <= 1'b0;
            snap_q <= '0;
        end else begin
            ac_q <= nxt;
            cg_q <= nxt_cg;
            if (!freeze) snap_q <= ac_q;
        end
    end

    assign ac     = ac_q;
    assign cg_sel = cg_q;
    assign snap   = snap_q;

endmodule

// File: rtl/lcdh_ram.sv
module lcdh_ram #(
    parameter int DEPTH = 80,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
    import lcdh_pkg::*;
#(
    parameter int DW        = 8,
    parameter int DD_DEPTH  = 80,
    parameter int CG_DEPTH  = 64,
    parameter int INSTR_CYC = 4,
    parameter int DATA_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          rs,
    input  logic          rw,
    input  logic          nib4,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          busy
);
    localparam int AW   = DW - 1;
    localparam int HW   = DW / 2;
    localparam int DDW  = $clog2(DD_DEPTH);
    localparam int CGW  = $clog2(CG_DEPTH);
    localparam int MAXC = (INSTR_CYC > DATA_CYC) ? INSTR_CYC : DATA_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    st_e            st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           take, byte_vld, lo_phase, exec;
    op_e            bop;
    logic [DW-1:0]  bdata, dr_q, dout_q, rd_val, dd_rd, cg_rd;
    logic [AW-1:0]  ac, snap, nxt, stat_ac;
    logic           cg_sel, nxt_cg;
    logic           ld_dd, ld_cg, inc_ac, we_dd, we_cg;

    lcdh_nibble #(.DW(DW)) u_nib (
        .clk(clk), .rst_n(rst_n), .acc(acc), .rs(rs), .rw(rw), .nib4(nib4),
        .allow(!busy), .din(din), .take(take), .byte_vld(byte_vld),
        .op(bop), .bdata(bdata), .lo_phase(lo_phase)
    );

    assign exec   = byte_vld && (bop != OP_STAT);
    assign ld_dd  = exec && (bop == OP_IRW) && bdata[DW-1];
    assign ld_cg  = exec && (bop == OP_IRW) && (bdata[DW-1:DW-2] == 2'b01);
    assign inc_ac = exec && (bop == OP_DRW || bop == OP_DRR);
    assign we_dd  = exec && (bop == OP_DRW) && !cg_sel;
    assign we_cg  = exec && (bop == OP_DRW) && cg_sel;

    lcdh_addr #(.AW(AW), .DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH)) u_addr (
        .clk(clk), .rst_n(rst_n), .ld_dd(ld_dd), .ld_cg(ld_cg),
        .ld_val(bdata[AW-1:0]), .inc(inc_ac), .freeze(busy),
        .ac(ac), .cg_sel(cg_sel), .snap(snap), .nxt(nxt), .nxt_cg(nxt_cg)
    );

    lcdh_ram #(.DEPTH(DD_DEPTH), .DW(DW)) u_ddram (
        .clk(clk), .we(we_dd), .waddr(ac[DDW-1:0]), .wdata(bdata),
        .raddr(nxt[DDW-1:0]), .rdata(dd_rd)
    );

    lcdh_ram #(.DEPTH(CG_DEPTH), .DW(DW)) u_cgram (
        .clk(clk), .we(we_cg), .waddr(ac[CGW-1:0]), .wdata(bdata),
        .raddr(nxt[CGW-1:0]), .rdata(cg_rd)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_READY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        busy  = 1'b0;
        unique case (st_q)
            ST_READY: begin
                if (exec) begin
                    st_d  = ST_BUSY;
                    cnt_d = (bop == OP_IRW) ? CW'(INSTR_CYC - 1) : CW'(DATA_CYC - 1);
                end
            end
            ST_BUSY: begin
                busy = 1'b1;
                if (cnt_q == '0) st_d = ST_READY;
                else             cnt_d = cnt_q - 1'b1;
            end
        endcase
    end

    assign stat_ac = busy ? snap : ac;
    assign rd_val  = rs ? dr_q : {busy, stat_ac};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_q   <= '0;
            dout_q <= '0;
        end else begin
            if (ld_dd || ld_cg || (exec && bop == OP_DRR))
                dr_q <= nxt_cg ? cg_rd : dd_rd;
            else if (exec && bop == OP_DRW)
                dr_q <= bdata;
            if (take && rw) begin
                if (nib4)
                    dout_q <= {(lo_phase ? rd_val[HW-1:0] : rd_val[DW-1:HW]), {HW{1'b0}}};
                else
                    dout_q <= rd_val;
            end
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk #(
    parameter int AW       = 7,
    parameter int DD_DEPTH = 80
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          acc,
    input logic          rs,
    input logic          rw,
    input logic [AW-1:0] ac,
    input logic          cg_sel,
    input logic [AW-1:0] snap,
    input logic          byte_vld,
    input logic [1:0]    bop,
    input logic          lo_phase
);
    localparam logic [AW-1:0] DD_LAST = AW'(DD_DEPTH - 1);

    AST_AC_IN_DD: assert property (@(posedge clk) disable iff (!rst_n)
        !cg_sel |-> ac <= DD_LAST);                                         // R3
    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(snap));                          // R2
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && acc && !(!rs && rw)) |=> ac == $past(ac));                 // R9
    AST_EXEC_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && byte_vld && bop != 2'b01) |=> busy);                      // R8
    AST_DD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && byte_vld && bop[1] && !cg_sel && ac == DD_LAST) |=> ac == '0); // R7
    AST_PHASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && bop == 2'b00) |=> !lo_phase);                          // R11

endmodule

bind lcd_host_if lcd_host_if_chk #(.AW(AW), .DD_DEPTH(DD_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .acc(acc), .rs(rs), .rw(rw),
    .ac(ac), .cg_sel(cg_sel), .snap(snap), .byte_vld(byte_vld),
    .bop(bop), .lo_phase(lo_phase)
);

// File: tb/tb_lcd_host_if.sv
module tb_lcd_host_if;
    localparam int CLK_PERIOD = 10;
    localparam int INSTR_CYC  = 4;
    localparam int DATA_CYC   = 2;
    localparam int WAITC      = INSTR_CYC + 2;

    logic clk = 1'b0, rst_n = 1'b0, acc = 1'b0, rs = 1'b0, rw = 1'b0, nib4 = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       busy;

    int nchk = 0, nfail = 0;
    bit done = 0;

    logic [7:0] mdd [80];
    logic [7:0] mcg [64];
    logic [6:0] mac;
    logic       msel;
    logic [7:0] mdr;

    lcd_host_if #(.INSTR_CYC(INSTR_CYC), .DATA_CYC(DATA_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .acc(acc), .rs(rs), .rw(rw), .nib4(nib4),
        .din(din), .dout(dout), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [6:0] f_inc(input logic [6:0] a, input logic c);
        if (c) return (a == 7'd63) ? 7'd0 : a + 7'd1;
        return (a == 7'd79) ? 7'd0 : a + 7'd1;
    endfunction

    function automatic logic [7:0] f_mem(input logic [6:0] a, input logic c);
        return c ? mcg[a[5:0]] : mdd[a];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic r_s, input logic r_w, input logic [7:0] d, output logic [7:0] q);
        acc = 1'b1; rs = r_s; rw = r_w; din = d;
        @(negedge clk);
        acc = 1'b0;
        q = dout;
    endtask

    task automatic put(input logic r_s, input logic [7:0] d);
        logic [7:0] q;
        if (nib4) begin
            cyc(r_s, 1'b0, {d[7:4], 4'h0}, q);
            cyc(r_s, 1'b0, {d[3:0], 4'h0}, q);
        end else begin
            cyc(r_s, 1'b0, d, q);
        end
    endtask

    task automatic get(input logic r_s, output logic [7:0] v);
        logic [7:0] q1, q2;
        if (nib4) begin
            cyc(r_s, 1'b1, 8'h00, q1);
            cyc(r_s, 1'b1, 8'h00, q2);
            chk("R10 low half zero", {q1[3:0], q2[3:0]}, 8'h00);
            v = {q1[7:4], q2[7:4]};
        end else begin
            cyc(r_s, 1'b1, 8'h00, v);
        end
    endtask

    task automatic settle();
        repeat (WAITC) @(negedge clk);
    endtask

    function automatic void m_apply_instr(input logic [7:0] d);
        if (d[7]) begin
            msel = 1'b0;
            mac  = (d[6:0] >= 7'd80) ? d[6:0] - 7'd80 : d[6:0];
            mdr  = mdd[mac];
        end else if (d[6]) begin
            msel = 1'b1;
            mac  = {1'b0, d[5:0]};
            mdr  = mcg[d[5:0]];
        end
    endfunction

    task automatic m_instr(input logic [7:0] d);
        put(1'b0, d);
        m_apply_instr(d);
        settle();
    endtask

    task automatic m_write(input logic [7:0] d);
        put(1'b1, d);
        if (msel) mcg[mac[5:0]] = d; else mdd[mac] = d;
        mdr = d;
        mac = f_inc(mac, msel);
        settle();
    endtask

    task automatic m_read(input string req);
        logic [7:0] v;
        get(1'b1, v);
        chk(req, v, mdr);
        mac = f_inc(mac, msel);
        mdr = f_mem(mac, msel);
        settle();
    endtask

    task automatic m_stat(input string req);
        logic [7:0] v;
        get(1'b0, v);
        chk(req, v, {1'b0, mac});
    endtask

    task automatic random_ops(input int n);
        for (int i = 0; i < n; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel == 0)      m_instr(8'h80 | 8'($urandom_range(0, 127)));
            else if (sel == 1) m_instr(8'h40 | 8'($urandom_range(0, 63)));
            else if (sel == 2) m_instr(8'($urandom_range(0, 63)));
            else if (sel <= 5) m_write(8'($urandom));
            else if (sel <= 8) m_read("R6 random read");
            else               m_stat("R2 random status");
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] q, prev;
        void'($urandom(32'd1234));
        mac = '0; msel = 1'b0; mdr = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 dout after reset", dout, 8'h00);
        chk("R12 busy after reset", {7'd0, busy}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        m_stat("R12 R1 status after reset");

        // fill both RAMs (R5, R4)
        m_instr(8'h80);
        for (int i = 0; i < 80; i++) m_write(8'(i * 3 + 7));
        m_stat("R7 display wrap after fill");
        m_instr(8'h40);
        for (int i = 0; i < 64; i++) m_write(8'(i * 5 + 1));
        m_stat("R7 character wrap after fill");

        // R3 address forms
        m_instr(8'h80 | 8'd85);
        m_stat("R3 display address above 79");
        m_read("R4 prefetch after address set");
        m_instr(8'h7F);
        m_stat("R3 character address");
        m_instr(8'h15);
        m_stat("R3 non-address command keeps counter");
        m_read("R4 R7 character read at 63");
        m_stat("R7 character counter wrapped");

        // R7 display wrap on read
        m_instr(8'h80 | 8'd79);
        m_read("R6 read at 79");
        m_stat("R7 display counter wrapped");
        m_read("R6 prefetched address 0");

        // R8 busy interval for a command, R2 frozen address
        m_instr(8'h80 | 8'd5);
        put(1'b0, 8'h80 | 8'h20);
        chk("R8 busy after command", {7'd0, busy}, 8'h01);
        for (int k = 0; k <= INSTR_CYC; k++) begin
            cyc(1'b0, 1'b1, 8'h00, q);
            if (k < INSTR_CYC - 1) chk("R2 R8 status while busy", q, {1'b1, 7'd5});
            else if (k == INSTR_CYC) chk("R8 status after command", q, {1'b0, 7'h20});
        end
        m_apply_instr(8'h80 | 8'h20);
        settle();

        // R8 data busy interval
        put(1'b1, 8'hA5);
        mdd[mac] = 8'hA5; mdr = 8'hA5; mac = f_inc(mac, msel);
        for (int k = 0; k <= DATA_CYC; k++) begin
            cyc(1'b0, 1'b1, 8'h00, q);
            if (k < DATA_CYC - 1) chk("R8 status while data busy", q, {1'b1, 7'h20});
            else if (k == DATA_CYC) chk("R8 status after data", q, {1'b0, 7'h21});
        end
        settle();
        m_instr(8'h80 | 8'h20);
        m_read("R5 written byte read back");

        // R9 accesses while busy are ignored
        prev = dout;
        put(1'b0, 8'h80 | 8'h10);
        m_apply_instr(8'h80 | 8'h10);
        cyc(1'b1, 1'b0, 8'hEE, q);
        cyc(1'b1, 1'b1, 8'h00, q);
        chk("R9 data read while busy leaves dout", q, prev);
        cyc(1'b0, 1'b0, 8'h80 | 8'h33, q);
        settle();
        m_stat("R9 counter unchanged by busy accesses");
        m_read("R9 location unchanged by busy write");

        random_ops(300);

        // 4-bit mode
        nib4 = 1'b1;
        settle();
        m_instr(8'h80 | 8'd12);
        m_stat("R11 R10 status after narrow command");
        m_write(8'h3C);
        m_instr(8'h80 | 8'd12);
        m_read("R10 narrow read back");
        m_instr(8'h40 | 8'd63);
        m_write(8'h9E);
        m_stat("R10 R7 narrow character wrap");
        random_ops(300);

        nib4 = 1'b0;
        settle();
        m_stat("R1 status back in wide mode");
        random_ops(100);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule